// File: doc/BRIEF.md
# Multi-Lane Sample Packer with Ring Addressing

The block takes one sample from each of several parallel lanes on every cycle in which all lanes offer data. It joins those samples into one input vector and packs the vectors, bit for bit, into much wider memory words. The input width need not divide the word width. Bits left over at the top of a word carry into the next word, also across the edges of sample blocks. Each finished word leaves the block with the memory address it is to be written to.

Addresses run upward from zero inside a ring. The ring length is a whole number of sample blocks, each block allotted `BLOCK_LEN*LANES*SAMPLE_W/WORD_W + 1` word addresses (integer division). The number of blocks is `(2**ADDR_W - 1) / words_per_block`, also with integer division. The ring is that count times the words per block; with the defaults (12 lanes of 14 bits, 576-bit words, 1024-cycle blocks, 27-bit addresses) that is 448888 blocks of 299 words. A stop request lets the block finish the sample block in progress. The block then writes out any partly filled word padded with zeros, and halts until reset.

Both data edges use valid/ready. An input cycle is taken only when every lane's valid bit and `lane_ready` are high together. The output word is held stable with `out_valid` until `out_ready` accepts it. While a word waits, `lane_ready` is low, so back-pressure reaches the lanes in the same cycle. The parameters must satisfy `WORD_W > LANES*SAMPLE_W`, `BLOCK_LEN >= 2` and `ADDR_W <= 31`.

Top module: `lane_word_packer`

## Requirements
- R1: The input vector places lane 0's sample in the least significant `SAMPLE_W` bits and lane k's sample at bit offset `k*SAMPLE_W`.
- R2: Vectors are packed with no gaps. The earliest vector takes the lowest free bits of the current word. Bits that do not fit continue at bit 0 of the next word, across block boundaries as well.
- R3: With `out_ready` high, `out_valid` rises for one cycle on the clock cycle after the input cycle that fills a word's last bit, and not otherwise while streaming.
- R4: Successive output words carry consecutive addresses starting at 0 after reset.
- R5: Addresses wrap from ring length minus one back to 0. The ring length is `((2**ADDR_W-1)/(BLOCK_LEN*LANES*SAMPLE_W/WORD_W+1)) * (BLOCK_LEN*LANES*SAMPLE_W/WORD_W+1)`, using integer division (14 for the bench's small configuration).
- R6: While `out_valid` is high and `out_ready` is low, `out_word` and `out_addr` hold their values and `lane_ready` is low.
- R7: A cycle in which any lane's valid bit is low takes no sample from any lane.
- R8: After `stop_req`, input is still taken until the count of taken cycles is a multiple of `BLOCK_LEN`. A partly filled word is then emitted with zeros above its last sample bit, after which `stopped` rises.
- R9: Once high, `stopped` stays high and `lane_ready` stays low until reset.
- R10: A synchronous active-high reset clears the carry bits, the fill count, the address and the stop state. After reset, `out_valid` and `stopped` are low and `lane_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lane_valid | input | LANES | Per-lane valid bits |
| lane_data | input | LANES*SAMPLE_W | Lane samples, lane 0 in the low bits |
| lane_ready | output | 1 | Block can take an input cycle |
| stop_req | input | 1 | Request to halt after the current block |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Sink accepts the output word |
| out_word | output | WORD_W | Packed memory word |
| out_addr | output | ADDR_W | Write address for `out_word` |
| stopped | output | 1 | Sticky halted indication |

## Verification
A wrong fill count or a corrupted carry register shows up in the very next emitted word. It appears either as shifted samples or as a word issued one vector too early or too late. Every later word is then shifted in the same way, so unpacking each word against the arithmetic bit stream exposes it within one word. An address counter fault shows as a break in the address sequence, or as a wrap at the wrong place, at the first word after the fault. A block counter fault shows as a stop that halts at a sample count that is not a multiple of the block length.

// File: rtl/packer_pkg.sv
package packer_pkg;

  typedef enum logic [1:0] {
    PK_RUN   = 2'd0,
    PK_FLUSH = 2'd1,
    PK_DONE  = 2'd2
  } pk_state_e;

  // word addresses set aside for one sample block
  function automatic int unsigned words_per_block(int unsigned blk_bits, int unsigned word_w);
    return blk_bits / word_w + 1;
  endfunction

  // whole blocks of addresses that fit under the top address
  function automatic int unsigned ring_words(int unsigned addr_w, int unsigned wpb);
    int unsigned top_adr;
    top_adr = (32'd1 << addr_w) - 32'd1;
    return (top_adr / wpb) * wpb;
  endfunction

endpackage

// File: rtl/lane_bit_packer.sv
module lane_bit_packer #(
  parameter int VEC_W  = 168,
  parameter int WORD_W = 576
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              flush,
  input  logic [VEC_W-1:0]  vec,
  output logic [WORD_W-1:0] word_o,
  output logic              emit_o
);
  localparam int CW = WORD_W + VEC_W;
  localparam int FW = $clog2(WORD_W);
  localparam int SW = $clog2(WORD_W + VEC_W);

  logic [WORD_W-1:0] acc_q;
  logic [FW-1:0]     fill_q;
  logic [CW-1:0]     merged;
  logic [SW-1:0]     sum;
  logic              full;

  always_comb begin
    merged = {{VEC_W{1'b0}}, acc_q} | ({{WORD_W{1'b0}}, vec} << fill_q);
    sum    = SW'(fill_q) + SW'(VEC_W);
    full   = sum >= SW'(WORD_W);
    emit_o = (take && full) || (flush && (fill_q != '0));
    word_o = flush ? acc_q : merged[WORD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      fill_q <= '0;
    end else if (flush) begin
      acc_q  <= '0;
      fill_q <= '0;
    end else if (take) begin
      if (full) begin
        acc_q  <= WORD_W'(merged >> WORD_W);
        fill_q <= FW'(sum - SW'(WORD_W));
      end else begin
        acc_q  <= merged[WORD_W-1:0];
        fill_q <= FW'(sum);
      end
    end
  end

  assert_fill_in_word_R2: assert property (@(posedge clk) disable iff (rst)
    int'(fill_q) < WORD_W);
  assert_carry_clean_above_fill_R2: assert property (@(posedge clk) disable iff (rst)
    (acc_q >> fill_q) == '0);
  assert_take_flush_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(take && flush));

endmodule

// File: rtl/addr_ring.sv
module addr_ring #(
  parameter int ADDR_W = 27,
  parameter int RING   = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else if (step) addr_q <= (addr_q == ADDR_W'(RING - 1)) ? '0 : addr_q + 1'b1;
  end

  assign addr_o = addr_q;

  assert_addr_in_ring_R5: assert property (@(posedge clk) disable iff (rst)
    int'(addr_q) < RING);
  assert_addr_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(addr_q));

endmodule

// File: rtl/lane_word_packer.sv
module lane_word_packer
  import packer_pkg::*;
#(
  parameter int LANES     = 12,
  parameter int SAMPLE_W  = 14,
  parameter int WORD_W    = 576,
  parameter int BLOCK_LEN = 1024,
  parameter int ADDR_W    = 27
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES-1:0]          lane_valid,
  input  logic [LANES*SAMPLE_W-1:0] lane_data,
  output logic                      lane_ready,
  input  logic                      stop_req,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [WORD_W-1:0]         out_word,
  output logic [ADDR_W-1:0]         out_addr,
  output logic                      stopped
);
  localparam int VEC_W    = LANES * SAMPLE_W;
  localparam int BLK_BITS = BLOCK_LEN * VEC_W;
  localparam int WPB      = int'(words_per_block(BLK_BITS, WORD_W));
  localparam int RING     = int'(ring_words(ADDR_W, WPB));
  localparam int BW       = $clog2(BLOCK_LEN);

  logic [VEC_W-1:0] vec;
  logic             take, flush, emit, slot_free, at_edge, stop_pend;
  logic [WORD_W-1:0] word;
  logic [ADDR_W-1:0] addr;
  logic [BW-1:0]     blk_cnt;
  pk_state_e         st;

  // lane k lands at bit offset k*SAMPLE_W
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign vec[k*SAMPLE_W +: SAMPLE_W] = lane_data[k*SAMPLE_W +: SAMPLE_W];
  end

  assign slot_free  = !out_valid || out_ready;
  assign at_edge    = stop_pend && (blk_cnt == '0);
  assign lane_ready = (st == PK_RUN) && !at_edge && slot_free;
  assign take       = lane_ready && (&lane_valid);
  assign flush      = (st == PK_FLUSH) && slot_free;
  assign stopped    = (st == PK_DONE);

  lane_bit_packer #(.VEC_W(VEC_W), .WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst(rst), .take(take), .flush(flush),
    .vec(vec), .word_o(word), .emit_o(emit)
  );

  addr_ring #(.ADDR_W(ADDR_W), .RING(RING)) u_ring (
    .clk(clk), .rst(rst), .step(emit), .addr_o(addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_cnt   <= '0;
      stop_pend <= 1'b0;
      st        <= PK_RUN;
    end else begin
      stop_pend <= stop_pend | stop_req;
      if (take) blk_cnt <= (blk_cnt == BW'(BLOCK_LEN - 1)) ? '0 : blk_cnt + 1'b1;
      case (st)
        PK_RUN:   if (at_edge) st <= PK_FLUSH;
        PK_FLUSH: if (slot_free) st <= PK_DONE;
        default:  st <= PK_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_addr  <= '0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_word  <= word;
      out_addr  <= addr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_under_backpressure_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_addr));
  assert_no_take_while_blocked_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !lane_ready);
  assert_stopped_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    stopped |=> stopped);
  assert_stopped_blocks_input_R9: assert property (@(posedge clk) disable iff (rst)
    stopped |-> !lane_ready);
  assert_halt_on_block_edge_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(stopped) |-> blk_cnt == '0);

endmodule

// File: tb/tb_lane_word_packer.sv
module tb_lane_word_packer;
  localparam int LANES = 3, SW = 4, WW = 32, BL = 4, AW = 4;
  localparam int VW = LANES * SW;
  localparam int RING = 14;

  logic clk = 0, rst = 1;
  logic [LANES-1:0] lane_valid = '0;
  logic [VW-1:0] lane_data = '0;
  logic lane_ready, stop_req = 0, out_valid, out_ready = 1, stopped;
  logic [WW-1:0] out_word;
  logic [AW-1:0] out_addr;

  lane_word_packer #(.LANES(LANES), .SAMPLE_W(SW), .WORD_W(WW), .BLOCK_LEN(BL), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .lane_valid(lane_valid), .lane_data(lane_data), .lane_ready(lane_ready),
    .stop_req(stop_req), .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_addr(out_addr), .stopped(stopped)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int nacc = 0, nw = 0;
  logic [8191:0] stream = '0;
  bit exp_v = 0, tchk = 0, bpchk = 0, pend = 0;
  logic [WW-1:0] held_w;
  logic [AW-1:0] held_a;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 50000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // monitor: samples at the falling edge
  always @(negedge clk) begin
    if (rst) begin
      nacc = 0; nw = 0; stream = '0; exp_v = 0; pend = 0;
    end else begin
      if (tchk) chk(out_valid == exp_v, "R3 word valid timing", out_valid, exp_v);
      if (bpchk && pend) begin
        chk(out_valid && out_word == held_w && out_addr == held_a, "R6 held word",
            {out_word, out_addr}, {held_w, held_a});
      end
      if (bpchk && out_valid && !out_ready)
        chk(!lane_ready, "R6 lane_ready low under back-pressure", lane_ready, 0);
      pend = out_valid && !out_ready;
      held_w = out_word; held_a = out_addr;
      if (out_valid && out_ready) begin
        chk(out_word == stream[nw*WW +: WW], "R1 R2 packed word", out_word, stream[nw*WW +: WW]);
        chk(int'(out_addr) == nw % RING, "R4 R5 address", out_addr, nw % RING);
        nw++;
      end
      exp_v = 0;
      if (lane_ready && (&lane_valid)) begin
        exp_v = ((nacc*VW + VW) / WW) != ((nacc*VW) / WW);
        stream[nacc*VW +: VW] = lane_data;
        nacc++;
      end
    end
  end

  task automatic drive(logic [LANES-1:0] v, int seed);
    @(posedge clk); #1;
    lane_valid = v;
    for (int l = 0; l < LANES; l++)
      lane_data[l*SW +: SW] = SW'((seed*7 + l*5 + 1) ^ (seed >> 2));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(!out_valid, "R10 out_valid after reset", out_valid, 0);
    chk(!stopped, "R10 stopped after reset", stopped, 0);
    chk(lane_ready, "R10 lane_ready after reset", lane_ready, 1);

    // streaming with gaps and partial valids
    tchk = 1;
    for (int i = 0; i < 120; i++)
      drive((i % 7 == 3) ? 3'b101 : (i % 11 == 5) ? 3'b000 : (i % 13 == 8) ? 3'b011 : 3'b111, i);
    drive(3'b000, 0);
    repeat (2) @(negedge clk);
    tchk = 0;
    chk(nw == (nacc*VW)/WW, "R7 word count vs full-valid cycles", nw, (nacc*VW)/WW);
    chk(nacc > 2*RING, "R5 enough words for wrap", nacc, 2*RING);

    // back-pressure
    bpchk = 1;
    for (int i = 0; i < 90; i++) begin
      drive(3'b111, i + 300);
      out_ready = (i % 3 != 0);
    end
    drive(3'b000, 0);
    out_ready = 1;
    repeat (3) @(negedge clk);
    bpchk = 0;

    // stop mid block
    drive(3'b111, 500);
    stop_req = 1;
    drive(3'b111, 501);
    stop_req = 0;
    for (int i = 0; i < 12; i++) drive(3'b111, 502 + i);
    repeat (4) @(negedge clk);
    chk(stopped, "R8 stopped raised", stopped, 1);
    chk(nacc % BL == 0, "R8 halt at block edge", nacc % BL, 0);
    chk(nw == (nacc*VW + WW - 1)/WW, "R8 partial word flushed", nw, (nacc*VW + WW - 1)/WW);
    for (int i = 0; i < 10; i++) begin
      drive(3'b111, 700 + i);
      stop_req = (i == 3);
    end
    @(negedge clk);
    chk(stopped && !lane_ready, "R9 stays halted", {stopped, lane_ready}, 2);
    chk(nacc % BL == 0, "R9 no input taken after halt", nacc % BL, 0);

    // reset again, address restarts at zero
    drive(3'b000, 0);
    rst = 1;
    repeat (2) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(!stopped && lane_ready && !out_valid, "R10 state after second reset",
        {stopped, lane_ready, out_valid}, 2);
    for (int i = 0; i < 6; i++) drive(3'b111, 900 + i);
    drive(3'b000, 0);
    repeat (3) @(negedge clk);
    chk(nw == 2, "R4 words after restart", nw, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule